// File: doc/BRIEF.md
# Dual-Signal Edge Ratio Counter

This block measures how two independent frame-rate signals drift against each other. A measurement window is a programmed number of rising edges on the frame-sync input. During that window the block counts the rising edges on the frame-start input. When the window closes, the start-edge total goes into a read-only result register. Host software compares successive results and uses them to adjust its own timing, which keeps buffers between the two time domains from overrunning or running dry.

Both inputs are asynchronous to the block clock. Each passes through a two-flop synchronizer and then a rising-edge detector, so an input pulse of any width is counted once. A small synchronous register port holds four registers: window length, control, result and status. The port also drives one interrupt output.

The block has two modes. In continuous mode a new window starts by itself after every capture. In halt mode the block stops after a capture and raises the interrupt, and a read of the result register re-arms it. Clearing the run bit acts as a software reset of the counters.

Top module: `edge_ratio_counter`

## Requirements
- R1: The window-length register (address 0) holds N. While the run bit is set, the result register (address 2) captures the number of frame-start rising edges seen between the start of the window and the N-th frame-sync rising edge.
- R2: A window length of zero behaves as a window of one frame-sync edge.
- R3: With control bit 1 clear (continuous mode), the result is refreshed at the close of every window and a new window begins without any register access. The interrupt does not rise in this mode.
- R4: With control bit 1 set (halt mode), a capture freezes both counters and drives the interrupt high. The interrupt stays high, and further input edges are ignored, until the result register is read.
- R5: In halt mode, a read of the result register clears the interrupt and opens a new window.
- R6: Control bit 0 is the run bit. Writing it to 0 clears both counters at once, even in the middle of a window. No capture takes place while it is 0.
- R7: Status bit 0 (address 3) is the full flag. A capture sets it and a read of the result register clears it.
- R8: A frame-start edge detected in the same cycle as the frame-sync edge that closes the window is counted into the window that closes.
- R9: The frame-start count saturates at its all-ones value and does not wrap.
- R10: After reset, all four registers read 0 and the interrupt is low.
- R11: A level held high on either input for many cycles counts as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; the data appears on reg_rdata one cycle later |
| reg_addr | input | 2 | Register address: 0 window length, 1 control, 2 result, 3 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| sync_in | input | 1 | Asynchronous frame-sync input that defines the window |
| start_in | input | 1 | Asynchronous frame-start input whose edges are counted |
| irq | output | 1 | Level interrupt raised by a capture in halt mode |

## Verification
The bench builds the block with DATA_W set to 4, so counts saturate at 15. This lets a window of five sync edges with four start edges each drive the counter into saturation within a few hundred cycles. A 16-bit build would need more than 65,000 start edges to do the same. The same narrow width keeps every window short, so the bench can sweep window lengths from zero to five. It also covers a mid-window stop, a start edge that coincides with the closing sync edge, and long held pulses in both modes.

// File: rtl/erc_pkg.sv
// Package: shared register address encoding and control bit positions
// for the edge ratio counter. It assumes a 2-bit register address.
package erc_pkg;

    typedef enum logic [1:0] {
        ADDR_WINDOW = 2'd0,
        ADDR_CTRL   = 2'd1,
        ADDR_RESULT = 2'd2,
        ADDR_STATUS = 2'd3
    } erc_addr_e;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_HALT_BIT = 1;
    localparam int STAT_FULL_BIT = 0;

endpackage

// File: rtl/erc_sync_edge.sv
// Module: erc_sync_edge
// Brings an asynchronous level into the clock domain through STAGES flops.
// It then emits a one-cycle pulse for each low-to-high transition.
// Assumes: the input stays at each level for at least two clock cycles.
module erc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], async_in};
        end
    end

    // A rising edge is a synchronized high whose previous value was low.
    always_comb begin
        rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
    end

    // R11: a detected edge lasts exactly one cycle.
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise)
        else $error("edge pulse longer than one cycle");

endmodule

// File: rtl/erc_window_counter.sv
// Module: erc_window_counter
// Counts frame-sync edges up to the programmed window length and counts
// frame-start edges inside that window with saturation. At the close of
// the window it emits a capture strobe carrying the start total. In halt
// mode it then freezes until rearm.
// Assumes: sync_rise and start_rise are single-cycle pulses in clk domain.
module erc_window_counter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              halt_mode,
    input  logic [DATA_W-1:0] window_len,
    input  logic              sync_rise,
    input  logic              start_rise,
    input  logic              rearm,
    output logic              capture,
    output logic [DATA_W-1:0] capture_val
);

    localparam logic [DATA_W-1:0] CNT_MAX = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] sync_cnt_q;
    logic [DATA_W-1:0] start_cnt_q;
    logic              halted_q;

    logic              active;
    logic [DATA_W-1:0] target;
    logic [DATA_W:0]   sync_next;
    logic              close_win;
    logic [DATA_W-1:0] start_sum;

    // Decide whether counting is live and whether this edge closes a window.
    always_comb begin
        active    = run && !halted_q;
        target    = (window_len == '0) ? ONE : window_len;
        sync_next = {1'b0, sync_cnt_q} + {{DATA_W{1'b0}}, 1'b1};
        close_win = active && sync_rise && (sync_next >= {1'b0, target});
        start_sum = (start_rise && start_cnt_q != CNT_MAX) ? start_cnt_q + ONE
                                                           : start_cnt_q;
    end

    // Capture output: the start total includes a coincident start edge.
    always_comb begin
        capture     = close_win;
        capture_val = start_sum;
    end

    // Counter state: stop reset, freeze, window close, or normal counting.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sync_cnt_q  <= '0;
            start_cnt_q <= '0;
            halted_q    <= 1'b0;
        end else if (halted_q) begin
            if (rearm) begin
                halted_q <= 1'b0;
            end
        end else if (close_win) begin
            sync_cnt_q  <= '0;
            start_cnt_q <= '0;
            halted_q    <= halt_mode;
        end else begin
            if (sync_rise) begin
                sync_cnt_q <= sync_next[DATA_W-1:0];
            end
            start_cnt_q <= start_sum;
        end
    end

    // R6: a cleared run bit leaves both counters at zero.
    p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sync_cnt_q == '0 && start_cnt_q == '0 && !capture))
        else $error("counters not cleared by stop");

    // R4: a frozen block keeps its counts until rearm.
    p_halt_freezes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_q && run && !rearm) |=> ($stable(start_cnt_q) && $stable(sync_cnt_q) && !capture))
        else $error("counting while halted");

    // R9: a saturated start count never wraps within a window.
    p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !halted_q && !close_win && start_cnt_q == CNT_MAX) |=> (start_cnt_q == CNT_MAX))
        else $error("start count wrapped");

    // R1: a closed window restarts the sync count from zero.
    p_close_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (sync_cnt_q == '0))
        else $error("sync count not restarted");

    // R2: with a zero length, every live sync edge closes the window.
    p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sync_rise && window_len == '0) |-> capture)
        else $error("zero length window did not close");

endmodule

// File: rtl/erc_regs.sv
// Module: erc_regs
// Register port holding window length, control, result and status, and
// driving the level interrupt. Reads are registered, so data appears one
// cycle after the strobe. A result read clears the flags and re-arms the
// counter. Assumes: at most one of write and read is used per cycle.
module erc_regs
    import erc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] capture_val,
    output logic [DATA_W-1:0] window_len,
    output logic              run,
    output logic              halt_mode,
    output logic              rearm,
    output logic              irq
);

    logic [DATA_W-1:0] window_q;
    logic              run_q;
    logic              halt_q;
    logic [DATA_W-1:0] result_q;
    logic              full_q;
    logic              irq_q;
    logic [DATA_W-1:0] rdata_q;

    // A read of the result register is the service and re-arm event.
    always_comb begin
        rearm = rd_en && (addr == ADDR_RESULT);
    end

    // Software-writable window length and control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window_q <= '0;
            run_q    <= 1'b0;
            halt_q   <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_WINDOW) begin
                window_q <= wdata;
            end else if (addr == ADDR_CTRL) begin
                run_q  <= wdata[CTRL_RUN_BIT];
                halt_q <= wdata[CTRL_HALT_BIT];
            end
        end
    end

    // Result register loads on each capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (capture) begin
            result_q <= capture_val;
        end
    end

    // Full flag and interrupt: a capture sets them, a result read clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (capture) begin
                full_q <= 1'b1;
            end else if (rearm) begin
                full_q <= 1'b0;
            end
            if (capture && halt_q) begin
                irq_q <= 1'b1;
            end else if (rearm) begin
                irq_q <= 1'b0;
            end
        end
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= '0;
            case (addr)
                ADDR_WINDOW: rdata_q <= window_q;
                ADDR_CTRL: begin
                    rdata_q[CTRL_RUN_BIT]  <= run_q;
                    rdata_q[CTRL_HALT_BIT] <= halt_q;
                end
                ADDR_RESULT: rdata_q <= result_q;
                default:     rdata_q[STAT_FULL_BIT] <= full_q;
            endcase
        end
    end

    // Drive outputs from the register state.
    always_comb begin
        window_len = window_q;
        run        = run_q;
        halt_mode  = halt_q;
        irq        = irq_q;
        rdata      = rdata_q;
    end

    // R4: the interrupt is never up without an unread result.
    p_irq_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> full_q)
        else $error("interrupt without full result");

    // R7: a capture leaves the full flag set.
    p_full_on_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> full_q)
        else $error("full flag not set by capture");

    // R5: a result read without a new capture clears flag and interrupt.
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm && !capture) |=> (!full_q && !irq_q))
        else $error("result read did not clear flags");

    // R3: continuous mode captures never raise the interrupt.
    p_cont_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_q && capture && !halt_q) |=> !irq_q)
        else $error("interrupt in continuous mode");

endmodule

// File: rtl/edge_ratio_counter.sv
// Module: edge_ratio_counter (top)
// Synchronizes the frame-sync and frame-start inputs and detects their
// rising edges. It feeds the edges to the window counter, which is
// controlled and read through the register block.
// Assumes: DATA_W >= 2 so that the control bits fit.
module edge_ratio_counter #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sync_in,
    input  logic              start_in,
    output logic              irq
);

    localparam int N_INPUTS  = 2;
    localparam int IDX_SYNC  = 0;
    localparam int IDX_START = 1;

    logic [N_INPUTS-1:0] raw_in;
    logic [N_INPUTS-1:0] rise_vec;

    logic [DATA_W-1:0] window_len;
    logic              run;
    logic              halt_mode;
    logic              rearm;
    logic              capture;
    logic [DATA_W-1:0] capture_val;

    // Gather the external inputs into one vector for the edge stage.
    always_comb begin
        raw_in[IDX_SYNC]  = sync_in;
        raw_in[IDX_START] = start_in;
    end

    // One synchronizer and edge detector per external input.
    for (genvar g = 0; g < N_INPUTS; g++) begin : g_edge
        erc_sync_edge #(
            .STAGES (SYNC_STAGES)
        ) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_in[g]),
            .rise     (rise_vec[g])
        );
    end

    erc_window_counter #(
        .DATA_W (DATA_W)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .halt_mode   (halt_mode),
        .window_len  (window_len),
        .sync_rise   (rise_vec[IDX_SYNC]),
        .start_rise  (rise_vec[IDX_START]),
        .rearm       (rearm),
        .capture     (capture),
        .capture_val (capture_val)
    );

    erc_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .rd_en       (reg_rd_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .capture     (capture),
        .capture_val (capture_val),
        .window_len  (window_len),
        .run         (run),
        .halt_mode   (halt_mode),
        .rearm       (rearm),
        .irq         (irq)
    );

endmodule

// File: tb/edge_ratio_counter_tb.sv
module edge_ratio_counter_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic         reg_rd_en = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         sync_in = 1'b0;
    logic         start_in = 1'b0;
    logic         irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    edge_ratio_counter #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sync_in(sync_in), .start_in(start_in), .irq(irq)
    );

    // Window length, start edges before each sync edge, expected result (halt mode).
    typedef struct packed {
        logic [3:0] win;
        logic [3:0] per_sync;
        logic [3:0] expect_v;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{4'd1, 4'd2, 4'd2},   // R1 single-edge window
        '{4'd3, 4'd1, 4'd3},   // R1 three-edge window
        '{4'd0, 4'd3, 4'd3},   // R2 zero length acts as one
        '{4'd4, 4'd3, 4'd12},  // R1 longer window
        '{4'd5, 4'd4, 4'd15},  // R9 twenty edges saturate at 15
        '{4'd2, 4'd0, 4'd0}    // R1 no start edges
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = int'(reg_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(input int hold);
        @(negedge clk); start_in = 1'b1;
        idle(hold); start_in = 1'b0;
        idle(3);
    endtask

    task automatic pulse_sync(input int hold);
        @(negedge clk); sync_in = 1'b1;
        idle(hold); sync_in = 1'b0;
        idle(3);
    endtask

    task automatic pulse_both();
        @(negedge clk); sync_in = 1'b1; start_in = 1'b1;
        idle(3); sync_in = 1'b0; start_in = 1'b0;
        idle(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        int d;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R10: reset state
        rd(2'd0, d); check("R10 window reg", d, 0);
        rd(2'd1, d); check("R10 ctrl reg", d, 0);
        rd(2'd2, d); check("R10 result reg", d, 0);
        rd(2'd3, d); check("R10 status reg", d, 0);
        check("R10 irq", int'(irq), 0);

        // Table walk in halt mode (R1, R2, R4, R5, R7, R9)
        foreach (VECS[i]) begin
            int nsync;
            wr(2'd1, 4'b0000);
            wr(2'd0, VECS[i].win);
            wr(2'd1, 4'b0011);
            nsync = (VECS[i].win == 0) ? 1 : int'(VECS[i].win);
            for (int s = 0; s < nsync; s++) begin
                for (int k = 0; k < int'(VECS[i].per_sync); k++) pulse_start(2);
                pulse_sync(2);
            end
            idle(4);
            check("R4 irq after capture", int'(irq), 1);
            rd(2'd3, d); check("R7 full after capture", d, 1);
            rd(2'd2, d); check("R1 vector result", d, int'(VECS[i].expect_v));
            check("R5 irq cleared by read", int'(irq), 0);
            rd(2'd3, d); check("R7 full cleared by read", d, 0);
        end

        // R4 / R5: edges ignored while halted, then re-arm
        wr(2'd1, 4'b0000);
        wr(2'd0, 4'd1);
        wr(2'd1, 4'b0011);
        pulse_start(2); pulse_start(2); pulse_sync(2);
        idle(4);
        pulse_start(2); pulse_start(2); pulse_start(2); pulse_sync(2);
        idle(4);
        check("R4 irq held while halted", int'(irq), 1);
        rd(2'd2, d); check("R4 result frozen while halted", d, 2);
        pulse_start(2); pulse_sync(2);
        idle(4);
        check("R5 irq after re-armed window", int'(irq), 1);
        rd(2'd2, d); check("R5 re-armed window result", d, 1);

        // R3: continuous mode
        wr(2'd1, 4'b0000);
        wr(2'd0, 4'd1);
        wr(2'd1, 4'b0001);
        pulse_start(2); pulse_start(2); pulse_sync(2);
        idle(4);
        check("R3 no irq in continuous", int'(irq), 0);
        rd(2'd3, d); check("R7 full in continuous", d, 1);
        rd(2'd2, d); check("R3 first window", d, 2);
        pulse_start(2); pulse_sync(2);
        idle(4);
        pulse_start(2); pulse_start(2); pulse_start(2); pulse_sync(2);
        idle(4);
        rd(2'd2, d); check("R3 auto restarted window", d, 3);
        check("R3 irq still low", int'(irq), 0);

        // R6: stop in the middle of a window
        wr(2'd1, 4'b0000);
        wr(2'd0, 4'd2);
        wr(2'd1, 4'b0011);
        pulse_start(2); pulse_start(2); pulse_start(2); pulse_sync(2);
        wr(2'd1, 4'b0010);
        pulse_sync(2);
        idle(4);
        rd(2'd3, d); check("R6 no capture while stopped", d, 0);
        wr(2'd1, 4'b0011);
        pulse_start(2); pulse_sync(2); pulse_sync(2);
        idle(4);
        rd(2'd2, d); check("R6 counters cleared by stop", d, 1);

        // R8: start edge coincident with the closing sync edge
        wr(2'd1, 4'b0000);
        wr(2'd0, 4'd1);
        wr(2'd1, 4'b0011);
        pulse_start(2); pulse_both();
        idle(4);
        rd(2'd2, d); check("R8 coincident start counted", d, 2);

        // R11: long held levels count once
        wr(2'd1, 4'b0000);
        wr(2'd0, 4'd2);
        wr(2'd1, 4'b0011);
        pulse_start(12); pulse_sync(10);
        idle(4);
        check("R11 long sync counted once", int'(irq), 0);
        pulse_sync(2);
        idle(4);
        rd(2'd2, d); check("R11 long start counted once", d, 1);

        // R1: window register read back
        rd(2'd0, d); check("R1 window readback", d, 2);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule